// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block turns host reads of a fixed-size address window into complete read sequences on a serial flash bus. A read at a window offset selects one flash device with its chip select and clocks out a read opcode on one line. The offset follows as one to four address bytes, most significant byte first, then zero to three dummy bytes. Four data bytes are then collected on one, two or four lines. The assembled 32-bit word is returned to the host with a one-cycle acknowledge.

Each chip select has its own setup register holding the opcode, the address byte count, the dummy byte count and the data line count. A control register carries the enable bit that hands the serial bus to this engine and the index of the chip select the window reads from. A read is answered with an error response, and the serial bus is left idle, when the engine is not enabled or when the access does not fit inside the window.

The serial clock idles low and runs at half the core clock. Outgoing bits change while the clock is low and are sampled by the flash on the rising edge. The engine samples incoming bits at the end of the high half.

Top module: `sflash_mmap_rd`

## Requirements
- R1: Out of reset, all chip selects are high, the serial clock is low, no data line is driven, no acknowledge is given, the mode output is 0, and every setup register is 0.
- R2: Control register index 0, bit 0, enables the engine and is reflected on `mm_mode_o` from the cycle after the write. A read while it is 0 is acknowledged with `rd_err_o`=1 one cycle after acceptance, and no chip select or serial clock edge occurs.
- R3: A read is accepted without error only when its byte offset is at most WIN_BYTES-4. A larger offset gets an error response and causes no serial bus activity.
- R4: A read asserts only the chosen chip select (active low). It sends setup bits 7:0 as the opcode on `io_o[0]`, MSB first, one bit per serial clock, with only `io_oe_o[0]` set.
- R5: Setup bits 9:8 hold the address byte count minus one. That many low-order bytes of the offset, plus one, follow the opcode on `io_o[0]`, MSB first.
- R6: Setup bits 11:10 give the dummy byte count n. After the address, 8*n serial clocks are issued while `io_oe_o` is 0.
- R7: Setup bits 13:12 select the data lines. Code 0 is single (`io_i[1]`, 32 clocks), code 1 is dual (`io_i[1:0]`, 16 clocks) and code 3 is quad (`io_i[3:0]`, 8 clocks). Code 2 behaves as single. Each byte arrives MSB first, and the highest-numbered line carries the highest bit of each group.
- R8: The first received byte lands in `rd_data_o[7:0]`, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R9: The setup register of chip select k is at control index k+1. Control index 0, bits 9:8, picks the chip select that window reads use.
- R10: On completion, `rd_ack_o` is high for exactly one cycle with the data, and by then all chip selects are high.
- R11: The setup and chip select are captured when a read is accepted. A control write landing in that same cycle, or during the transfer, affects only later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_addr_i | input | CAW (3) | Control register word index |
| cfg_wdata_i | input | 14 | Control register write data |
| rd_req_i | input | 1 | Window read request, held until acknowledge |
| rd_addr_i | input | AW (24) | Window byte offset |
| rd_ack_o | output | 1 | One-cycle read completion |
| rd_err_o | output | 1 | Error response, valid with acknowledge |
| rd_data_o | output | 32 | Read data, valid with acknowledge |
| mm_mode_o | output | 1 | Serial bus owned by this engine |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | NCS (4) | Chip selects, active low |
| io_o | output | 4 | Serial data lines out |
| io_oe_o | output | 4 | Serial data line output enables |
| io_i | input | 4 | Serial data lines in |

## Verification
A control write and the acceptance of a window read can fall in the same cycle. They collide when the write targets the setup register of the very chip select being read. The bench provokes this by launching a setup write to quad mode on the same clock edge that accepts a single-line read, and a second write during the transfer. It judges the outcome through an independent flash model: the ongoing read must show the clock count and data ordering of the old setup, and the next read the new one.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int CFG_DW = 14;

  typedef enum logic [1:0] {
    LN_SINGLE = 2'b00,
    LN_DUAL   = 2'b01,
    LN_RSVD   = 2'b10,
    LN_QUAD   = 2'b11
  } lane_e;

  typedef struct packed {
    lane_e      lanes;
    logic [1:0] dummy;
    logic [1:0] abytes_m1;
    logic [7:0] opcode;
  } setup_t;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DUMMY, S_DATA, S_DONE, S_ERR
  } st_e;
endpackage

// File: rtl/sfr_cfg_regs.sv
module sfr_cfg_regs
  import sfr_pkg::*;
#(
  parameter int NCS = 4,
  parameter int CSW = 2,
  parameter int CAW = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [CAW-1:0]          addr_i,
  input  logic [CFG_DW-1:0]       wdata_i,
  output setup_t [NCS-1:0]        setup_o,
  output logic                    mm_en_o,
  output logic [CSW-1:0]          cs_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mm_en_o  <= 1'b0;
      cs_sel_o <= '0;
    end else if (we_i && addr_i == '0) begin
      mm_en_o  <= wdata_i[0];
      cs_sel_o <= wdata_i[8 +: CSW];
    end
  end

  for (genvar k = 0; k < NCS; k++) begin : g_setup
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        setup_o[k] <= '0;
      else if (we_i && addr_i == CAW'(k + 1))
        setup_o[k] <= setup_t'(wdata_i);
    end
  end
endmodule

// File: rtl/sfr_win_chk.sv
module sfr_win_chk #(
  parameter int AW        = 24,
  parameter int WIN_BYTES = 4096
) (
  input  logic [AW-1:0] addr_i,
  output logic          ok_o
);
  localparam logic [AW-1:0] LAST_OK = AW'(WIN_BYTES - 4);
  assign ok_o = (addr_i <= LAST_OK);
endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
  import sfr_pkg::*;
#(
  parameter int NCS = 4,
  parameter int CSW = 2,
  parameter int AW  = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            fail_i,
  input  setup_t          setup_i,
  input  logic [CSW-1:0]  sel_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [3:0]      io_i,
  output logic            idle_o,
  output logic            sclk_o,
  output logic [NCS-1:0]  cs_no,
  output logic [3:0]      io_o,
  output logic [3:0]      io_oe_o,
  output logic            ack_o,
  output logic            err_o,
  output logic [31:0]     data_o
);
  localparam int HW = 40;

  st_e             st;
  logic            ph;
  logic [5:0]      cnt;
  logic [HW-1:0]   out_sh;
  logic [31:0]     in_sh, in_nxt, addr32, addr_al;
  logic [1:0]      dmy_q;
  lane_e           ln_q;
  logic [CSW-1:0]  sel_q;
  logic            busy;
  logic [5:0]      data_last, hdr_last;

  assign addr32 = 32'(addr_i);

  always_comb begin
    unique case (setup_i.abytes_m1)
      2'd0:    addr_al = {addr32[7:0], 24'b0};
      2'd1:    addr_al = {addr32[15:0], 16'b0};
      2'd2:    addr_al = {addr32[23:0], 8'b0};
      default: addr_al = addr32;
    endcase
  end

  // opcode plus (abytes_m1+1) address bytes, minus one
  assign hdr_last = {1'b0, setup_i.abytes_m1, 3'b111} + 6'd8;

  always_comb begin
    unique case (ln_q)
      LN_QUAD: begin data_last = 6'd7;  in_nxt = {in_sh[27:0], io_i}; end
      LN_DUAL: begin data_last = 6'd15; in_nxt = {in_sh[29:0], io_i[1:0]}; end
      default: begin data_last = 6'd31; in_nxt = {in_sh[30:0], io_i[1]}; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      ph     <= 1'b0;
      cnt    <= '0;
      out_sh <= '0;
      in_sh  <= '0;
      dmy_q  <= '0;
      ln_q   <= LN_SINGLE;
      sel_q  <= '0;
      data_o <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          if (fail_i) st <= S_ERR;
          else begin
            st     <= S_HDR;
            ph     <= 1'b0;
            cnt    <= hdr_last;
            out_sh <= {setup_i.opcode, addr_al};
            dmy_q  <= setup_i.dummy;
            ln_q   <= setup_i.lanes;
            sel_q  <= sel_i;
          end
        end
        S_HDR: begin
          ph <= ~ph;
          if (ph) begin
            out_sh <= out_sh << 1;
            if (cnt == '0) begin
              if (dmy_q != '0) begin
                st  <= S_DUMMY;
                cnt <= {1'b0, dmy_q - 2'd1, 3'b111};
              end else begin
                st  <= S_DATA;
                cnt <= data_last;
              end
            end else cnt <= cnt - 6'd1;
          end
        end
        S_DUMMY: begin
          ph <= ~ph;
          if (ph) begin
            if (cnt == '0) begin
              st  <= S_DATA;
              cnt <= data_last;
            end else cnt <= cnt - 6'd1;
          end
        end
        S_DATA: begin
          ph <= ~ph;
          if (ph) begin
            in_sh <= in_nxt;
            if (cnt == '0) begin
              st     <= S_DONE;
              data_o <= {in_nxt[7:0], in_nxt[15:8], in_nxt[23:16], in_nxt[31:24]};
            end else cnt <= cnt - 6'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st == S_HDR) || (st == S_DUMMY) || (st == S_DATA);
  assign idle_o  = (st == S_IDLE);
  assign sclk_o  = busy & ph;
  assign io_o    = (st == S_HDR) ? {3'b000, out_sh[HW-1]} : 4'b0000;
  assign io_oe_o = (st == S_HDR) ? 4'b0001 : 4'b0000;
  assign ack_o   = (st == S_DONE) || (st == S_ERR);
  assign err_o   = (st == S_ERR);

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign cs_no[k] = !(busy && sel_q == CSW'(k));
  end

  assert_cs_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  assert_sclk_framed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !(&cs_no));
  assert_oe_framed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|io_oe_o) |-> (!(&cs_no) && !sclk_o || !(&cs_no)));
  assert_cs_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&cs_no) && !(&$past(cs_no))) |-> $stable(cs_no));
endmodule

// File: rtl/sflash_mmap_rd.sv
module sflash_mmap_rd
  import sfr_pkg::*;
#(
  parameter int NCS       = 4,
  parameter int AW        = 24,
  parameter int WIN_BYTES = 4096,
  localparam int CSW      = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int CAW      = $clog2(NCS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CAW-1:0]    cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              rd_req_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic              rd_ack_o,
  output logic              rd_err_o,
  output logic [31:0]       rd_data_o,
  output logic              mm_mode_o,
  output logic              sclk_o,
  output logic [NCS-1:0]    cs_no,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_i
);
  localparam logic [AW-1:0] WIN_LAST = AW'(WIN_BYTES - 4);

  setup_t [NCS-1:0] setup_q;
  logic [CSW-1:0]   cs_sel;
  logic             win_ok, idle;

  sfr_cfg_regs #(.NCS(NCS), .CSW(CSW), .CAW(CAW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .setup_o  (setup_q),
    .mm_en_o  (mm_mode_o),
    .cs_sel_o (cs_sel)
  );

  sfr_win_chk #(.AW(AW), .WIN_BYTES(WIN_BYTES)) u_win (
    .addr_i (rd_addr_i),
    .ok_o   (win_ok)
  );

  sfr_seq #(.NCS(NCS), .CSW(CSW), .AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .start_i (rd_req_i),
    .fail_i  (!mm_mode_o || !win_ok),
    .setup_i (setup_q[cs_sel]),
    .sel_i   (cs_sel),
    .addr_i  (rd_addr_i),
    .io_i,
    .idle_o  (idle),
    .sclk_o,
    .cs_no,
    .io_o,
    .io_oe_o,
    .ack_o   (rd_ack_o),
    .err_o   (rd_err_o),
    .data_o  (rd_data_o)
  );

  assert_mode_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == '0) |=> (mm_mode_o == $past(cfg_wdata_i[0])));
  assert_off_err_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && idle && !mm_mode_o) |=> (rd_ack_o && rd_err_o && (&cs_no)));
  assert_oow_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && idle && rd_addr_i > WIN_LAST) |=> (rd_err_o && (&cs_no) && !sclk_o));
  assert_ack_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |=> !rd_ack_o);
  assert_ack_cs_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> (&cs_no));
endmodule

// File: tb/sflash_mmap_rd_bench.sv
module sflash_mmap_rd_bench;
  localparam int NCS = 4, AW = 24, WIN = 4096;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [13:0] cfg_wdata = 0;
  logic        rd_req = 0;
  logic [23:0] rd_addr = 0;
  logic        rd_ack, rd_err, mm_mode, sclk;
  logic [31:0] rd_data;
  logic [3:0]  cs_n, io_o, io_oe;
  logic [3:0]  io_i = 0;

  int checks = 0, fails = 0, cyc_all = 0;

  // flash model state
  int          m_ab = 1, m_db = 0, m_ln = 1, rises = 0, midx;
  logic [23:0] m_addr = 0;
  logic [39:0] hdr_cap = 0;
  logic [31:0] msh;
  logic [3:0]  cs_at = '1;
  bit          oe_bad = 0, cs_act = 0;

  always #2 clk = ~clk;

  sflash_mmap_rd u_sflash_mmap_rd (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_ack_o(rd_ack), .rd_err_o(rd_err), .rd_data_o(rd_data),
    .mm_mode_o(mm_mode), .sclk_o(sclk), .cs_no(cs_n), .io_o(io_o),
    .io_oe_o(io_oe), .io_i(io_i));

  function automatic logic [7:0] fb(input logic [23:0] a);
    return 8'((a * 37) ^ 24'hA5);
  endfunction

  function automatic logic [31:0] stream_of(input logic [23:0] a);
    return {fb(a), fb(a + 1), fb(a + 2), fb(a + 3)};
  endfunction

  function automatic logic [31:0] word_of(input logic [23:0] a);
    return {fb(a + 3), fb(a + 2), fb(a + 1), fb(a)};
  endfunction

  always @(posedge sclk) begin
    if (rises < 8 + 8 * m_ab) hdr_cap <= {hdr_cap[38:0], io_o[0]};
    else if (io_oe != 0) oe_bad <= 1;
    cs_at <= cs_n;
    rises <= rises + 1;
  end

  always @(negedge sclk) begin
    midx = rises - (8 + 8 * m_ab) - 8 * m_db;
    if (midx >= 0 && midx < 32 / m_ln) begin
      msh = stream_of(m_addr) >> (32 - (midx + 1) * m_ln);
      case (m_ln)
        4:       io_i <= msh[3:0];
        2:       io_i <= {2'b00, msh[1:0]};
        default: io_i <= {2'b00, msh[0], 1'b0};
      endcase
    end
  end

  always @(posedge clk) if (rst_n && !(&cs_n)) cs_act <= 1;

  always @(posedge clk) begin
    cyc_all <= cyc_all + 1;
    if (cyc_all > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [13:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [13:0] setup_w(input int ln_code, input int db, input int ab, input logic [7:0] op);
    return {2'(ln_code), 2'(db), 2'(ab - 1), op};
  endfunction

  task automatic model_cfg(input int ab, input int db, input int ln, input logic [23:0] a);
    m_ab = ab; m_db = db; m_ln = ln; m_addr = a;
  endtask

  task automatic do_read(input logic [23:0] a, output logic [31:0] d, output logic e);
    int n;
    @(negedge clk);
    rises = 0; hdr_cap = 0; oe_bad = 0; cs_at = '1; cs_act = 0;
    rd_addr = a; rd_req = 1; n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (rd_ack || n > 400) break;
    end
    check(rd_ack, "R10 ack seen", 64'(rd_ack), 1);
    d = rd_data; e = rd_err;
    rd_req = 0;
    @(negedge clk);
    check(!rd_ack, "R10 ack one cycle", 64'(rd_ack), 0);
  endtask

  task automatic t_reset;
    check(cs_n == 4'hF && !sclk && io_oe == 0 && !rd_ack && !mm_mode, "R1 reset outputs",
          {cs_n, 3'b0, sclk, io_oe, 3'b0, rd_ack, 3'b0, mm_mode}, 64'hF0000);
  endtask

  task automatic t_mode_off;
    logic [31:0] d; logic e;
    do_read(24'h10, d, e);
    check(e, "R2 error while disabled", 64'(e), 1);
    check(!cs_act && rises == 0, "R2 no bus activity", 64'(rises), 0);
    cfg_write(0, 14'h001);
    check(mm_mode, "R2 mode set", 64'(mm_mode), 1);
  endtask

  task automatic t_single;
    logic [31:0] d; logic e;
    cfg_write(1, setup_w(0, 0, 3, 8'h03));
    cfg_write(0, 14'h001);
    model_cfg(3, 0, 1, 24'h000124);
    do_read(24'h000124, d, e);
    check(!e, "R4 no error", 64'(e), 0);
    check(hdr_cap == 40'h0003000124, "R4 R5 opcode and address", hdr_cap, 40'h0003000124);
    check(rises == 64, "R7 single clock count", 64'(rises), 64);
    check(d == word_of(24'h124), "R8 single data order", d, word_of(24'h124));
    check(cs_at == 4'b1110, "R4 chip select 0", cs_at, 4'b1110);
  endtask

  task automatic t_window;
    logic [31:0] d; logic e;
    model_cfg(3, 0, 1, 24'(WIN - 4));
    do_read(24'(WIN - 4), d, e);
    check(!e && d == word_of(24'(WIN - 4)), "R3 last offset accepted", d, word_of(24'(WIN - 4)));
    do_read(24'(WIN - 3), d, e);
    check(e && !cs_act && rises == 0, "R3 out of window rejected", 64'(e), 1);
  endtask

  task automatic t_quad;
    logic [31:0] d; logic e;
    cfg_write(2, setup_w(3, 2, 4, 8'hEB));
    cfg_write(0, 14'h101);
    model_cfg(4, 2, 4, 24'h000AB0);
    do_read(24'h000AB0, d, e);
    check(hdr_cap == 40'hEB00000AB0, "R5 four address bytes", hdr_cap, 40'hEB00000AB0);
    check(rises == 64 && !oe_bad, "R6 R7 dummy and quad clocks", 64'(rises), 64);
    check(d == word_of(24'hAB0), "R7 R8 quad data", d, word_of(24'hAB0));
    check(cs_at == 4'b1101, "R9 chip select 1", cs_at, 4'b1101);
  endtask

  task automatic t_dual;
    logic [31:0] d; logic e;
    cfg_write(3, setup_w(1, 1, 1, 8'h3B));
    cfg_write(0, 14'h201);
    model_cfg(1, 1, 2, 24'h0000FC);
    do_read(24'h0000FC, d, e);
    check(hdr_cap == 40'h3BFC, "R5 one address byte", hdr_cap, 40'h3BFC);
    check(rises == 40 && !oe_bad, "R6 R7 dual clocks", 64'(rises), 40);
    check(d == word_of(24'hFC), "R7 dual data", d, word_of(24'hFC));
    check(cs_at == 4'b1011, "R9 chip select 2", cs_at, 4'b1011);
  endtask

  task automatic t_rsvd_lane;
    logic [31:0] d; logic e;
    cfg_write(4, setup_w(2, 3, 2, 8'h0B));
    cfg_write(0, 14'h301);
    model_cfg(2, 3, 1, 24'h000321);
    do_read(24'h000321, d, e);
    check(hdr_cap == 40'h0B0321, "R5 two address bytes", hdr_cap, 40'h0B0321);
    check(rises == 80 && !oe_bad, "R6 R7 code 2 as single", 64'(rises), 80);
    check(d == word_of(24'h321) && cs_at == 4'b0111, "R7 R9 code 2 data cs3", d, word_of(24'h321));
  endtask

  task automatic t_latch;
    logic [31:0] d; logic e;
    cfg_write(0, 14'h001);
    model_cfg(3, 0, 1, 24'h000200);
    fork
      do_read(24'h000200, d, e);
      cfg_write(1, setup_w(3, 0, 3, 8'h6B));
      begin repeat (20) @(negedge clk); cfg_write(1, setup_w(3, 0, 3, 8'h6B)); end
    join
    check(hdr_cap == 40'h0003000200 && rises == 64, "R11 old setup kept", 64'(rises), 64);
    check(d == word_of(24'h200), "R11 old setup data", d, word_of(24'h200));
    model_cfg(3, 0, 4, 24'h000200);
    do_read(24'h000200, d, e);
    check(hdr_cap == 40'h6B000200 && rises == 40, "R11 new setup used", 64'(rises), 40);
    check(d == word_of(24'h200), "R11 new setup data", d, word_of(24'h200));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_mode_off;
    t_single;
    t_window;
    t_quad;
    t_dual;
    t_rsvd_lane;
    t_latch;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule